// File: doc/BRIEF.md
# Inhibit-Aware Operand Bypass and Writeback Controller

This block steers operands and register-file writes for a four-lane, five-stage in-order pipeline (fetch, decode, execute, memory, writeback). Each operation in the bundle at decode carries one destination and two sources. Each of these carries a compiler-set inhibit flag. A set destination flag marks a short-lived result that should never reach the register file. A set source flag says that the operand will arrive over a bypass, so the register-file read address for that source is frozen and the read port does not toggle. The controller keeps a destination tag for every lane in the execute, memory and writeback stages. For every decode source it picks the youngest producer, and it drives the register-file write enables for the writeback lanes.

A two-state machine, `ST_RUN` and `ST_DRAIN`, handles recovery. An exception raised in decode, execute or memory, an interrupt, or an instruction-cache miss each cause a trigger. In the trigger cycle the machine forces writeback, which makes every inhibit flag count as clear. It then holds `ST_DRAIN` for three pipeline advances, so every result that was in flight reaches the register file. The transitions are: `ST_RUN` to `ST_DRAIN` on a trigger. `ST_DRAIN` to `ST_DRAIN` on a new trigger, which reloads the count, or on any cycle before the count runs out. `ST_DRAIN` to `ST_RUN` when the last advance of the count occurs with no new trigger. A data-cache stall freezes the pipeline and pauses the count, and normal inhibition stays allowed while it lasts. The parameter `EXACT` selects exact exception handling. In that mode, an inhibited read may only be satisfied by the two execute-stage bypasses. Without it, the decode-stage bypass is allowed as well.

Top module: `bypass_wb_ctrl`

## Requirements
- R1: For each source k (lane k/2, operand k%2), `op_sel[2k+1:2k]` gives the youngest matching producer that has a valid write to the same register: 1 when it is in execute (execute-to-execute bypass), 2 when it is in memory (memory-to-execute), 3 when it is in writeback (memory-to-decode), and 0 (register file) when nothing matches. Execute beats memory, and memory beats writeback.
- R2: For writeback lane i, `rf_we[i]` is high when that lane is valid, writes, has a clear write-inhibit flag and the pipeline is not stalled. `rf_waddr` for that lane then carries its destination register.
- R3: When a valid source has its read-inhibit flag set and writeback is not forced, its `rf_raddr` field repeats the value it had in the previous cycle. Otherwise the field carries the source register number.
- R4: With `EXACT`=1, `inh_miss[k]` is high when an effective inhibited read has a selection of 0 or 3, and low otherwise.
- R5: With `EXACT`=0, `inh_miss[k]` is high only when an effective inhibited read has a selection of 0.
- R6: When `exc_req`, `irq_req` or `imiss_req` is high, `force_wb` rises in the same cycle. While `force_wb` is high, write-inhibit flags are ignored, so write-inhibited writeback lanes are written. Read-inhibit flags are also ignored, so addresses follow the sources and `inh_miss` stays low.
- R7: After the last trigger, `force_wb` stays high for exactly three more non-stalled cycles. A new trigger during this time restarts the count.
- R8: While `stall` is high, all stage tags hold their values and every `rf_we` bit is low.
- R9: After reset, no stage holds a valid tag, `force_wb` is low and every `rf_we` bit is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| stall | input | 1 | Data-cache stall: freezes the pipeline |
| exc_req | input | 1 | Exception raised in decode, execute or memory |
| irq_req | input | 1 | Interrupt accepted |
| imiss_req | input | 1 | Instruction-cache miss |
| id_valid | input | 4 | Decode lane holds an operation |
| id_dst | input | 24 | Destination register per lane, 6 bits each |
| id_wr | input | 4 | Decode lane writes its destination |
| id_winh | input | 4 | Write-inhibit flag per lane |
| id_src | input | 48 | Source registers, 6 bits each, index lane*2+operand |
| id_rinh | input | 8 | Read-inhibit flag per source |
| rf_raddr | output | 48 | Register-file read address per source |
| op_sel | output | 16 | Operand source per source, 2 bits each |
| inh_miss | output | 8 | Inhibited read that has no permitted bypass |
| rf_we | output | 4 | Register-file write enable per writeback lane |
| rf_waddr | output | 24 | Register-file write address per writeback lane |
| force_wb | output | 1 | Forced writeback is active |

## Verification
The assertions assume that `stall` never coincides with a trigger that needs an immediate pipeline advance, and that no two lanes of one bundle write the same register. They also assume that reset is held for at least one clock edge before the first checked cycle. The stimulus draws source and destination registers from only eight values, so bypass hits in every stage are frequent. It keeps the trigger rate low, so drain windows both overlap and end cleanly. Stalls are injected about one cycle in ten, and duplicate destinations within a bundle only affect the lane index, never the stage that the selection reports.

// File: rtl/bwc_pkg.sv
package bwc_pkg;

    typedef enum logic [1:0] {
        SRC_RF    = 2'd0,
        SRC_EXEX  = 2'd1,
        SRC_MEMEX = 2'd2,
        SRC_MEMID = 2'd3
    } src_e;

    typedef enum logic {
        ST_RUN   = 1'b0,
        ST_DRAIN = 1'b1
    } drain_e;

endpackage

// File: rtl/bwc_tag_pipe.sv
module bwc_tag_pipe #(
    parameter int LANES = 4,
    parameter int AW    = 6
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  stall,
    input  logic [LANES-1:0]      in_valid,
    input  logic [LANES-1:0]      in_wr,
    input  logic [LANES-1:0]      in_winh,
    input  logic [LANES*AW-1:0]   in_dst,
    output logic [LANES-1:0]      ex_v,
    output logic [LANES-1:0]      ex_w,
    output logic [LANES*AW-1:0]   ex_d,
    output logic [LANES-1:0]      mem_v,
    output logic [LANES-1:0]      mem_w,
    output logic [LANES*AW-1:0]   mem_d,
    output logic [LANES-1:0]      wb_v,
    output logic [LANES-1:0]      wb_w,
    output logic [LANES-1:0]      wb_i,
    output logic [LANES*AW-1:0]   wb_d
);
    localparam int STAGES = 3;

    logic [LANES-1:0]    v_q [STAGES];
    logic [LANES-1:0]    w_q [STAGES];
    logic [LANES-1:0]    i_q [STAGES];
    logic [LANES*AW-1:0] d_q [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) begin
                v_q[s] <= '0;
                w_q[s] <= '0;
                i_q[s] <= '0;
                d_q[s] <= '0;
            end
        end else if (!stall) begin
            v_q[0] <= in_valid;
            w_q[0] <= in_wr;
            i_q[0] <= in_winh;
            d_q[0] <= in_dst;
            for (int s = 1; s < STAGES; s++) begin
                v_q[s] <= v_q[s-1];
                w_q[s] <= w_q[s-1];
                i_q[s] <= i_q[s-1];
                d_q[s] <= d_q[s-1];
            end
        end
    end

    assign ex_v  = v_q[0];
    assign ex_w  = w_q[0];
    assign ex_d  = d_q[0];
    assign mem_v = v_q[1];
    assign mem_w = w_q[1];
    assign mem_d = d_q[1];
    assign wb_v  = v_q[2];
    assign wb_w  = w_q[2];
    assign wb_i  = i_q[2];
    assign wb_d  = d_q[2];

    // A stalled cycle must leave the writeback tags untouched (R8)
    assert_stall_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        stall |=> ($stable(wb_v) && $stable(wb_d) && $stable(mem_v) && $stable(ex_v)));

endmodule

// File: rtl/bwc_drain_fsm.sv
module bwc_drain_fsm
    import bwc_pkg::*;
#(
    parameter int DRAIN_CYC = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic stall,
    input  logic trig,
    output logic force_wb
);
    localparam int CW = $clog2(DRAIN_CYC + 1);
    localparam logic [CW-1:0] CNT_LOAD = CW'(DRAIN_CYC);
    localparam logic [CW-1:0] CNT_ONE  = CW'(1);

    drain_e        state_q, state_n;
    logic [CW-1:0] cnt_q, cnt_n;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_RUN;
            cnt_q   <= '0;
        end else begin
            state_q <= state_n;
            cnt_q   <= cnt_n;
        end
    end

    always_comb begin
        state_n = state_q;
        cnt_n   = cnt_q;
        unique case (state_q)
            ST_RUN: begin
                if (trig) begin
                    state_n = ST_DRAIN;
                    cnt_n   = CNT_LOAD;
                end
            end
            ST_DRAIN: begin
                if (trig) begin
                    cnt_n = CNT_LOAD;
                end else if (!stall) begin
                    if (cnt_q == CNT_ONE) begin
                        state_n = ST_RUN;
                        cnt_n   = '0;
                    end else begin
                        cnt_n = cnt_q - CNT_ONE;
                    end
                end
            end
            default: begin
                state_n = ST_RUN;
                cnt_n   = '0;
            end
        endcase
    end

    always_comb begin
        unique case (state_q)
            ST_RUN:   force_wb = trig;
            ST_DRAIN: force_wb = 1'b1;
            default:  force_wb = 1'b1;
        endcase
    end

    assert_trig_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
        trig |=> force_wb);

    assert_drain_count_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DRAIN) |-> (cnt_q != '0));

    assert_drain_ends_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DRAIN && cnt_q == CNT_ONE && !stall && !trig) |=> (state_q == ST_RUN));

endmodule

// File: rtl/bwc_operand_sel.sv
module bwc_operand_sel
    import bwc_pkg::*;
#(
    parameter int   LANES = 4,
    parameter int   AW    = 6,
    parameter bit   EXACT = 1'b1
) (
    input  logic [AW-1:0]         src,
    input  logic                  rd_inh,
    input  logic [LANES-1:0]      ex_v,
    input  logic [LANES-1:0]      ex_w,
    input  logic [LANES*AW-1:0]   ex_d,
    input  logic [LANES-1:0]      mem_v,
    input  logic [LANES-1:0]      mem_w,
    input  logic [LANES*AW-1:0]   mem_d,
    input  logic [LANES-1:0]      wb_v,
    input  logic [LANES-1:0]      wb_w,
    input  logic [LANES*AW-1:0]   wb_d,
    output src_e                  sel,
    output logic                  miss
);
    logic [LANES-1:0] hit_ex, hit_mem, hit_wb;
    logic             path_ok;

    for (genvar l = 0; l < LANES; l++) begin : g_cmp
        assign hit_ex[l]  = ex_v[l]  & ex_w[l]  & (ex_d[l*AW +: AW]  == src);
        assign hit_mem[l] = mem_v[l] & mem_w[l] & (mem_d[l*AW +: AW] == src);
        assign hit_wb[l]  = wb_v[l]  & wb_w[l]  & (wb_d[l*AW +: AW]  == src);
    end

    always_comb begin
        if (|hit_ex)       sel = SRC_EXEX;
        else if (|hit_mem) sel = SRC_MEMEX;
        else if (|hit_wb)  sel = SRC_MEMID;
        else               sel = SRC_RF;
    end

    if (EXACT) begin : g_exact
        assign path_ok = (sel == SRC_EXEX) || (sel == SRC_MEMEX);
    end else begin : g_inexact
        assign path_ok = (sel != SRC_RF);
    end

    assign miss = rd_inh & ~path_ok;

endmodule

// File: rtl/bypass_wb_ctrl.sv
module bypass_wb_ctrl
    import bwc_pkg::*;
#(
    parameter int LANES     = 4,
    parameter int NSRC      = 2,
    parameter int AW        = 6,
    parameter int DRAIN_CYC = 3,
    parameter bit EXACT     = 1'b1
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        stall,
    input  logic                        exc_req,
    input  logic                        irq_req,
    input  logic                        imiss_req,
    input  logic [LANES-1:0]            id_valid,
    input  logic [LANES*AW-1:0]         id_dst,
    input  logic [LANES-1:0]            id_wr,
    input  logic [LANES-1:0]            id_winh,
    input  logic [LANES*NSRC*AW-1:0]    id_src,
    input  logic [LANES*NSRC-1:0]       id_rinh,
    output logic [LANES*NSRC*AW-1:0]    rf_raddr,
    output logic [LANES*NSRC*2-1:0]     op_sel,
    output logic [LANES*NSRC-1:0]       inh_miss,
    output logic [LANES-1:0]            rf_we,
    output logic [LANES*AW-1:0]         rf_waddr,
    output logic                        force_wb
);
    localparam int OPS = LANES * NSRC;

    logic [LANES-1:0]    ex_v, ex_w, mem_v, mem_w, wb_v, wb_w, wb_i;
    logic [LANES*AW-1:0] ex_d, mem_d, wb_d;
    logic [OPS*AW-1:0]   raddr_q;
    logic                trig;
    logic                past_ok;

    assign trig = exc_req | irq_req | imiss_req;

    bwc_tag_pipe #(.LANES(LANES), .AW(AW)) u_tags (
        .clk(clk), .rst_n(rst_n), .stall(stall),
        .in_valid(id_valid), .in_wr(id_wr), .in_winh(id_winh), .in_dst(id_dst),
        .ex_v(ex_v), .ex_w(ex_w), .ex_d(ex_d),
        .mem_v(mem_v), .mem_w(mem_w), .mem_d(mem_d),
        .wb_v(wb_v), .wb_w(wb_w), .wb_i(wb_i), .wb_d(wb_d)
    );

    bwc_drain_fsm #(.DRAIN_CYC(DRAIN_CYC)) u_drain (
        .clk(clk), .rst_n(rst_n), .stall(stall), .trig(trig), .force_wb(force_wb)
    );

    for (genvar k = 0; k < OPS; k++) begin : g_op
        localparam int LN = k / NSRC;
        logic  inh_eff;
        src_e  sel;

        assign inh_eff = id_valid[LN] & id_rinh[k] & ~force_wb;

        bwc_operand_sel #(.LANES(LANES), .AW(AW), .EXACT(EXACT)) u_sel (
            .src(id_src[k*AW +: AW]), .rd_inh(inh_eff),
            .ex_v(ex_v), .ex_w(ex_w), .ex_d(ex_d),
            .mem_v(mem_v), .mem_w(mem_w), .mem_d(mem_d),
            .wb_v(wb_v), .wb_w(wb_w), .wb_d(wb_d),
            .sel(sel), .miss(inh_miss[k])
        );

        assign op_sel[k*2 +: 2]     = sel;
        assign rf_raddr[k*AW +: AW] = inh_eff ? raddr_q[k*AW +: AW] : id_src[k*AW +: AW];

        assert_raddr_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
            (past_ok && inh_eff) |-> (rf_raddr[k*AW +: AW] == $past(rf_raddr[k*AW +: AW])));

        assert_rf_sel_miss_R4: assert property (@(posedge clk) disable iff (!rst_n)
            (inh_eff && sel == SRC_RF) |-> inh_miss[k]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            raddr_q <= '0;
            past_ok <= 1'b0;
        end else begin
            raddr_q <= rf_raddr;
            past_ok <= 1'b1;
        end
    end

    for (genvar i = 0; i < LANES; i++) begin : g_wb
        assign rf_we[i] = wb_v[i] & wb_w[i] & (~wb_i[i] | force_wb) & ~stall;

        assert_forced_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
            (force_wb && !stall && wb_v[i] && wb_w[i]) |-> rf_we[i]);
    end

    assign rf_waddr = wb_d;

    assert_no_write_stall_R8: assert property (@(posedge clk) disable iff (!rst_n)
        stall |-> (rf_we == '0));

    assert_force_no_miss_R6: assert property (@(posedge clk) disable iff (!rst_n)
        force_wb |-> (inh_miss == '0));

    assert_trig_forces_R6: assert property (@(posedge clk) disable iff (!rst_n)
        trig |-> force_wb);

endmodule

// File: tb/test_bypass_wb_ctrl.sv
module test_bypass_wb_ctrl;
    localparam int PERIOD = 10;
    localparam int L  = 4;
    localparam int NS = 2;
    localparam int AW = 6;
    localparam int OPS = L * NS;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic stall = 1'b0, exc_req = 1'b0, irq_req = 1'b0, imiss_req = 1'b0;
    logic [L-1:0]      id_valid = '0, id_wr = '0, id_winh = '0;
    logic [L*AW-1:0]   id_dst = '0;
    logic [OPS*AW-1:0] id_src = '0;
    logic [OPS-1:0]    id_rinh = '0;

    logic [OPS*AW-1:0] raddr_a, raddr_b;
    logic [OPS*2-1:0]  sel_a, sel_b;
    logic [OPS-1:0]    miss_a, miss_b;
    logic [L-1:0]      we_a, we_b;
    logic [L*AW-1:0]   waddr_a, waddr_b;
    logic              frc_a, frc_b;

    int n_chk = 0;
    int n_fail = 0;

    always #(PERIOD/2) clk = ~clk;

    bypass_wb_ctrl #(.EXACT(1'b1)) i_bypass_wb_ctrl (
        .clk(clk), .rst_n(rst_n), .stall(stall), .exc_req(exc_req), .irq_req(irq_req),
        .imiss_req(imiss_req), .id_valid(id_valid), .id_dst(id_dst), .id_wr(id_wr),
        .id_winh(id_winh), .id_src(id_src), .id_rinh(id_rinh), .rf_raddr(raddr_a),
        .op_sel(sel_a), .inh_miss(miss_a), .rf_we(we_a), .rf_waddr(waddr_a), .force_wb(frc_a)
    );

    bypass_wb_ctrl #(.EXACT(1'b0)) i_bypass_wb_ctrl_inexact (
        .clk(clk), .rst_n(rst_n), .stall(stall), .exc_req(exc_req), .irq_req(irq_req),
        .imiss_req(imiss_req), .id_valid(id_valid), .id_dst(id_dst), .id_wr(id_wr),
        .id_winh(id_winh), .id_src(id_src), .id_rinh(id_rinh), .rf_raddr(raddr_b),
        .op_sel(sel_b), .inh_miss(miss_b), .rf_we(we_b), .rf_waddr(waddr_b), .force_wb(frc_b)
    );

    // reference model state: stage 0 = execute, 1 = memory, 2 = writeback
    logic [L-1:0]  mv [3];
    logic [L-1:0]  mw [3];
    logic [L-1:0]  mi [3];
    logic [AW-1:0] md [3][L];
    logic [AW-1:0] mq [OPS];
    logic [AW-1:0] eraddr [OPS];
    int            mcnt;

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic model_reset();
        for (int s = 0; s < 3; s++) begin
            mv[s] = '0; mw[s] = '0; mi[s] = '0;
            for (int l = 0; l < L; l++) md[s][l] = '0;
        end
        for (int k = 0; k < OPS; k++) mq[k] = '0;
        mcnt = 0;
    endtask

    function automatic int best_stage(input logic [AW-1:0] s);
        int b = 0;
        for (int st = 2; st >= 0; st--)
            for (int l = 0; l < L; l++)
                if (mv[st][l] && mw[st][l] && md[st][l] == s) b = st + 1;
        return b;
    endfunction

    task automatic check_outputs();
        logic trig, frc, rinh, e, ma, mb;
        logic [AW-1:0] s;
        int b;
        trig = exc_req | irq_req | imiss_req;
        frc  = trig || (mcnt > 0);
        chk(trig ? "R6 force_wb on trigger" : "R7 force_wb drain window", 64'(frc_a), 64'(frc));
        chk("R7 force_wb inexact instance", 64'(frc_b), 64'(frc));
        for (int k = 0; k < OPS; k++) begin
            s    = id_src[k*AW +: AW];
            b    = best_stage(s);
            rinh = id_rinh[k] && !frc && id_valid[k/NS];
            eraddr[k] = rinh ? mq[k] : s;
            ma = rinh && (b == 0 || b == 3);
            mb = rinh && (b == 0);
            chk("R1 op_sel priority", 64'(sel_a[k*2 +: 2]), 64'(b));
            chk("R1 op_sel inexact", 64'(sel_b[k*2 +: 2]), 64'(b));
            chk(frc ? "R6 raddr follows source when forced" : "R3 raddr hold",
                64'(raddr_a[k*AW +: AW]), 64'(eraddr[k]));
            chk(frc ? "R6 no miss when forced" : "R4 exact miss", 64'(miss_a[k]), 64'(ma));
            chk("R5 inexact miss", 64'(miss_b[k]), 64'(mb));
        end
        for (int l = 0; l < L; l++) begin
            e = mv[2][l] && mw[2][l] && (!mi[2][l] || frc) && !stall;
            chk(stall ? "R8 no write in stall" : (frc ? "R6 forced write" : "R2 write enable"),
                64'(we_a[l]), 64'(e));
            chk("R2 write enable inexact", 64'(we_b[l]), 64'(e));
            if (e) chk("R2 write address", 64'(waddr_a[l*AW +: AW]), 64'(md[2][l]));
        end
    endtask

    task automatic model_step();
        logic trig;
        trig = exc_req | irq_req | imiss_req;
        for (int k = 0; k < OPS; k++) mq[k] = eraddr[k];
        if (trig) mcnt = 3;
        else if (mcnt > 0 && !stall) mcnt--;
        if (!stall) begin
            for (int s = 2; s > 0; s--) begin
                mv[s] = mv[s-1]; mw[s] = mw[s-1]; mi[s] = mi[s-1];
                for (int l = 0; l < L; l++) md[s][l] = md[s-1][l];
            end
            mv[0] = id_valid; mw[0] = id_wr; mi[0] = id_winh;
            for (int l = 0; l < L; l++) md[0][l] = id_dst[l*AW +: AW];
        end
    endtask

    task automatic cycle();
        @(negedge clk);
        check_outputs();
        @(posedge clk);
        model_step();
        #1;
    endtask

    task automatic idle_inputs();
        stall = 1'b0; exc_req = 1'b0; irq_req = 1'b0; imiss_req = 1'b0;
        id_valid = '0; id_wr = '0; id_winh = '0; id_dst = '0; id_src = '0; id_rinh = '0;
    endtask

    task automatic random_inputs();
        int r;
        idle_inputs();
        for (int l = 0; l < L; l++) begin
            id_valid[l] = ($urandom_range(0, 9) < 8);
            id_wr[l]    = ($urandom_range(0, 9) < 7);
            id_winh[l]  = ($urandom_range(0, 1) == 1);
            id_dst[l*AW +: AW] = AW'($urandom_range(0, 7));
        end
        for (int k = 0; k < OPS; k++) begin
            id_src[k*AW +: AW] = AW'($urandom_range(0, 7));
            id_rinh[k] = ($urandom_range(0, 2) != 0);
        end
        stall = ($urandom_range(0, 9) == 0);
        r = $urandom_range(0, 39);
        exc_req   = (r == 0);
        irq_req   = (r == 1);
        imiss_req = (r == 2);
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    endtask

    initial begin
        #(PERIOD * 150000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired: actual=hung expected=finished");
        summary();
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        model_reset();
        idle_inputs();
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1'b1;

        // R9 reset state
        @(negedge clk);
        chk("R9 force_wb after reset", 64'(frc_a), 64'd0);
        chk("R9 rf_we after reset", 64'(we_a), 64'd0);
        chk("R9 op_sel after reset", 64'(sel_a), 64'd0);
        @(posedge clk); model_step(); #1;

        // directed: producer r5 write-inhibited in lane 0, consumers follow
        idle_inputs();
        id_valid = 4'b0001; id_wr = 4'b0001; id_winh = 4'b0001; id_dst[0 +: AW] = 6'd5;
        cycle();
        idle_inputs();
        id_valid = 4'b0010; id_src[2*AW +: AW] = 6'd5; id_rinh[2] = 1'b1;   // R1 execute bypass
        cycle();
        idle_inputs();
        cycle();
        // producer now in writeback: R4 exact flags miss, R5 inexact accepts; R2 write suppressed
        id_valid = 4'b0100; id_src[4*AW +: AW] = 6'd5; id_rinh[4] = 1'b1;
        cycle();
        // R6: write-inhibited result in writeback is forced out by an exception
        idle_inputs();
        id_valid = 4'b0001; id_wr = 4'b0001; id_winh = 4'b0001; id_dst[0 +: AW] = 6'd9;
        cycle();
        idle_inputs();
        cycle();
        cycle();
        exc_req = 1'b1;
        id_valid = 4'b0001; id_rinh[0] = 1'b1; id_src[0 +: AW] = 6'd9;
        cycle();
        // R7 drain with a stall in the middle, then a retrigger
        idle_inputs();
        cycle();
        stall = 1'b1;
        cycle();
        stall = 1'b0;
        cycle();
        imiss_req = 1'b1;
        cycle();
        idle_inputs();
        repeat (5) cycle();
        irq_req = 1'b1;
        cycle();
        idle_inputs();
        repeat (4) cycle();

        // constrained random
        for (int n = 0; n < 4000; n++) begin
            random_inputs();
            cycle();
        end
        idle_inputs();
        repeat (4) cycle();

        summary();
        $finish;
    end

endmodule